// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves one frame of data at a time between a parallel word and a three-wire serial link. The link has a serial clock, an input data line and an output data line. A runtime setting selects the role. In master role the port generates the serial clock itself, by dividing the system clock. In slave role it follows a clock supplied from outside, which it brings into the system clock domain through a synchroniser and an edge detector. Two further runtime settings select a frame of 8 or 16 bits and the bit order, least significant bit first or most significant bit first.

Software sets up the role, order, width and divider, places a word on `tx_data` and pulses `start`. At that moment the port latches the word and every setting. The port is then busy until the last bit has been sampled. At that point the received word appears on `rx_data` and `done_irq` pulses for one cycle. On the link, the port launches each outgoing bit on a falling serial clock edge and samples each incoming bit on the next rising edge. The serial clock rests high between frames.

The sequencer has three states. `ST_IDLE` waits for `start`. `ST_WAIT_FALL` waits for a falling clock event and then launches a bit. `ST_WAIT_RISE` waits for a rising clock event and then samples a bit. The transitions are as follows:
- IDLE to WAIT_FALL when `start` is accepted.
- WAIT_FALL to WAIT_RISE on a fall event.
- WAIT_RISE to WAIT_FALL on a rise event for any bit except the last.
- WAIT_RISE to IDLE on the rise event of the last bit. This transition raises `done_irq`.

Top module: `sio_port`

## Requirements
- R1: After reset, `busy`, `done_irq` and `rx_data` are 0, and `sck_o` and `sout` are 1.
- R2: In master role (`cfg_master`=1), `sck_oe` is 1 and the port drives `sck_o`. The serial clock period is 2^(`cfg_div`+1) system clocks, so a frame of N bits holds `sck_o` low for N·2^`cfg_div` system clocks. `sck_o` is high whenever `busy` is 0.
- R3: `sout` changes during a transfer only on a falling serial clock event, and `sin` is sampled on the rising event that follows it. A bit therefore travels in both directions on each clock pulse.
- R4: With `cfg_lsb_first`=1, bit 0 is sent and received first. With `cfg_lsb_first`=0, the top bit of the frame (bit 7 or bit 15) goes first.
- R5: With `cfg_wide`=1, a frame is 16 bits. With `cfg_wide`=0, a frame is 8 bits, `tx_data[15:8]` is never sent, and `rx_data[15:8]` reads 0 after the transfer.
- R6: In slave role (`cfg_master`=0), `sck_oe` is 0. The port shifts on edges of `sck_i`, which pass through a two-flop synchroniser, so `sout` follows a falling edge of `sck_i` by three system clocks.
- R7: `done_irq` is a single-cycle pulse. It occurs in the cycle where `busy` falls, and `rx_data` carries the received frame in that same cycle.
- R8: A `start` pulse while `busy` is 1 has no effect: it does not reload the transmit word, and it neither restarts nor adds a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_div | input | 2 | Master clock divider exponent; period = 2^(cfg_div+1) |
| tx_data | input | 16 | Word to send, latched on accepted start |
| start | input | 1 | Start request, one cycle, accepted when idle |
| rx_data | output | 16 | Last received frame |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion interrupt |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sck_i | input | 1 | Serial clock from the pin, used in slave role |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output, rests at 1 |

## Verification
The checks assume that `sin` is stable in the system clocks leading up to each rising serial clock event. They also assume that, in slave role, the external clock sits high when `start` arrives and stays in each phase for several system clocks, longer than the synchroniser delay. The stimulus follows these assumptions. In master role, the bench's slave model changes `sin` one nanosecond after each falling edge of `sck_o`. In slave role, the bench holds each phase of `sck_i` for six system clocks, and it changes `sin` only together with a falling edge.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_FALL = 2'd1,
        ST_WAIT_RISE = 2'd2
    } sio_state_t;

    typedef struct packed {
        logic master;
        logic lsb_first;
        logic wide;
    } sio_mode_t;
endpackage

// File: rtl/sio_mclk.sv
`timescale 1ns/1ps
// Master serial clock: half period of 2^div system clocks, idles high.
module sio_mclk #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             fall_evt,
    output logic             rise_evt
);
    localparam int HCNT_W = (1 << DIV_W) - 1;

    logic [HCNT_W-1:0] cnt;
    logic [HCNT_W:0]   half_n;
    logic [HCNT_W-1:0] limit;
    logic              tick;

    assign half_n   = {{HCNT_W{1'b0}}, 1'b1} << div;
    assign limit    = HCNT_W'(half_n - 1'b1);
    assign tick     = en && (cnt == limit);
    assign fall_evt = tick && sck;
    assign rise_evt = tick && !sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (!en) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sio_sync.sv
`timescale 1ns/1ps
// Synchronises an external clock pin and flags its edges.
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];
    assign rise = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
    import sio_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int DIV_W    = 2,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_lsb_first,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              start,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done_irq,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    input  logic              sin,
    output logic              sout
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0]  LAST_WIDE   = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  LAST_NARROW = IDX_W'(NARROW_W - 1);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    sio_state_t        state, nxt;
    sio_mode_t         mode_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] tx_q, rx_sh, rx_q, rx_next;
    logic [IDX_W-1:0]  bidx, last_idx, pos;
    logic              sout_q, done_q;
    logic              m_sck, m_fall, m_rise, s_fall, s_rise;
    logic              fall_evt, rise_evt, start_acc, last_bit;

    sio_mclk #(.DIV_W(DIV_W)) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy && mode_q.master),
        .div      (div_q),
        .sck      (m_sck),
        .fall_evt (m_fall),
        .rise_evt (m_rise)
    );

    sio_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_i),
        .fall  (s_fall),
        .rise  (s_rise)
    );

    assign busy      = (state != ST_IDLE);
    assign start_acc = (state == ST_IDLE) && start;
    assign fall_evt  = mode_q.master ? m_fall : s_fall;
    assign rise_evt  = mode_q.master ? m_rise : s_rise;
    assign last_idx  = mode_q.wide ? LAST_WIDE : LAST_NARROW;
    assign pos       = mode_q.lsb_first ? bidx : (last_idx - bidx);
    assign last_bit  = (bidx == last_idx);

    always_comb begin
        rx_next      = rx_sh;
        rx_next[pos] = sin;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start)    nxt = ST_WAIT_FALL;
            ST_WAIT_FALL: if (fall_evt) nxt = ST_WAIT_RISE;
            ST_WAIT_RISE: if (rise_evt) nxt = last_bit ? ST_IDLE : ST_WAIT_FALL;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
            tx_q   <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
            bidx   <= '0;
            sout_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_acc) begin
                        mode_q <= '{master: cfg_master, lsb_first: cfg_lsb_first,
                                    wide: cfg_wide};
                        div_q  <= cfg_div;
                        tx_q   <= cfg_wide ? tx_data : (tx_data & NARROW_MASK);
                        rx_sh  <= '0;
                        bidx   <= '0;
                    end
                end
                ST_WAIT_FALL: begin
                    if (fall_evt) sout_q <= tx_q[pos];
                end
                ST_WAIT_RISE: begin
                    if (rise_evt) begin
                        rx_sh <= rx_next;
                        if (last_bit) begin
                            rx_q   <= rx_next;
                            done_q <= 1'b1;
                            sout_q <= 1'b1;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rx_data  = rx_q;
    assign done_irq = done_q;
    assign sout     = sout_q;
    assign sck_o    = m_sck;
    assign sck_oe   = busy ? mode_q.master : cfg_master;
endmodule

// File: rtl/sio_port_chk.sv
`timescale 1ns/1ps
module sio_port_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       done_irq,
    input logic                       sck_o,
    input logic                       sout,
    input logic                       start,
    input logic                       wide_q,
    input logic                       fall_evt,
    input logic [DATA_W-1:0]          tx_q,
    input logic [DATA_W-NARROW_W-1:0] rx_hi
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq);

    // R2
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);

    // R3
    sout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (sout != $past(sout))) |-> $past(fall_evt));

    // R5
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !wide_q) |-> (rx_hi == '0));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tx_q));
endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done_irq (done_irq),
    .sck_o    (sck_o),
    .sout     (sout),
    .start    (start),
    .wide_q   (mode_q.wide),
    .fall_evt (fall_evt),
    .tx_q     (tx_q),
    .rx_hi    (rx_data[DATA_W-1:NARROW_W])
);

// File: tb/sim_sio_port.sv
`timescale 1ns/1ps
module sim_sio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_lsb_first = 1'b1, cfg_wide = 1'b1;
    logic [1:0]  cfg_div = 2'd0;
    logic [15:0] tx_data = '0;
    logic        start = 1'b0;
    logic [15:0] rx_data;
    logic        busy, done_irq, sck_o, sck_oe;
    logic        sck_i = 1'b1, sin = 1'b0;
    logic        sout;

    int checks = 0, fails = 0, done_cnt = 0;

    // bench slave model for master-role tests
    logic [15:0] mdl_send, mdl_got;
    int          mdl_k = 0, mdl_n = 16;
    logic        mdl_lsb = 1'b1;

    always #2.5 clk = ~clk;

    sio_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
        .cfg_wide(cfg_wide), .cfg_div(cfg_div), .tx_data(tx_data), .start(start),
        .rx_data(rx_data), .busy(busy), .done_irq(done_irq), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_i(sck_i), .sin(sin), .sout(sout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int order_idx(input int k, input int n, input logic lsb);
        return lsb ? k : (n - 1 - k);
    endfunction

    initial forever begin
        @(negedge clk);
        if (done_irq) done_cnt++;
    end

    initial begin
        mdl_got = '0;
        mdl_send = '0;
        forever begin
            @(negedge sck_o);
            #1;
            if (mdl_k < mdl_n) begin
                mdl_got[order_idx(mdl_k, mdl_n, mdl_lsb)] = sout;
                sin = mdl_send[order_idx(mdl_k, mdl_n, mdl_lsb)];
                mdl_k++;
            end
        end
    end

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done_irq", done_irq, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 sck_o", sck_o, 1);
        chk("R1 sout", sout, 1);
    endtask

    // R2 R3 R4 R5 R7: master transfer against the bench slave model
    task automatic t_master(input logic [1:0] div, input logic lsb, input logic wide,
                            input logic [15:0] tx, input logic [15:0] slv);
        int n, low, d0;
        logic [15:0] mask;
        n = wide ? 16 : 8;
        mask = wide ? 16'hFFFF : 16'h00FF;
        mdl_n = n; mdl_k = 0; mdl_lsb = lsb; mdl_send = slv; mdl_got = '0;
        cfg_master = 1'b1; cfg_div = div; cfg_lsb_first = lsb; cfg_wide = wide;
        tx_data = tx; d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 sck_oe master", sck_oe, 1);
        low = 0;
        while (busy) begin
            if (!sck_o) low++;
            @(negedge clk);
        end
        chk("R7 done with busy fall", done_irq, 1);
        chk("R5 R7 rx_data", rx_data, slv & mask);
        chk("R3 R4 sent word", mdl_got, tx & mask);
        chk("R2 low cycles", low, n * (1 << div));
        @(negedge clk);
        chk("R7 single pulse", done_irq, 0);
        chk("R7 one done", done_cnt - d0, 1);
        chk("R2 sck idle", sck_o, 1);
    endtask

    // R6: slave transfer with bench-driven clock
    task automatic t_slave(input logic lsb, input logic wide,
                           input logic [15:0] tx, input logic [15:0] mst);
        int n, d0, idx;
        logic [15:0] got, mask;
        n = wide ? 16 : 8;
        mask = wide ? 16'hFFFF : 16'h00FF;
        got = '0;
        cfg_master = 1'b0; cfg_lsb_first = lsb; cfg_wide = wide; tx_data = tx;
        sck_i = 1'b1; d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R6 busy", busy, 1);
        chk("R6 sck_oe slave", sck_oe, 0);
        for (int k = 0; k < n; k++) begin
            idx = order_idx(k, n, lsb);
            sck_i = 1'b0;
            sin = mst[idx];
            repeat (2) @(negedge clk);
            if (k == 0) chk("R6 sout not yet", sout, 1);
            repeat (4) @(negedge clk);
            got[idx] = sout;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
        end
        while (busy) @(negedge clk);
        chk("R6 R4 sent word", got, tx & mask);
        chk("R6 R5 rx_data", rx_data, mst & mask);
        chk("R6 R7 one done", done_cnt - d0, 1);
    endtask

    // R8: start pulses during a transfer
    task automatic t_busy_start();
        int d0;
        mdl_n = 16; mdl_k = 0; mdl_lsb = 1'b1; mdl_send = 16'h5AA5; mdl_got = '0;
        cfg_master = 1'b1; cfg_div = 2'd1; cfg_lsb_first = 1'b1; cfg_wide = 1'b1;
        tx_data = 16'h8421; d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (9) @(negedge clk);
        tx_data = 16'h7777; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        chk("R8 word unchanged", mdl_got, 16'h8421);
        repeat (4) @(negedge clk);
        chk("R8 no restart", busy, 0);
        chk("R8 single done", done_cnt - d0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_master(2'd0, 1'b1, 1'b1, 16'h1234, 16'hBEEF);
        t_master(2'd1, 1'b0, 1'b1, 16'hC3A5, 16'h0F0F);
        t_master(2'd3, 1'b1, 1'b0, 16'hA55A, 16'hFF96);
        t_master(2'd2, 1'b0, 1'b0, 16'h0081, 16'h0042);
        t_slave(1'b1, 1'b1, 16'h9C31, 16'h6E0B);
        t_slave(1'b0, 1'b0, 16'hF0C2, 16'h1234);
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule